// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block turns the module clock into the 16x oversampling tick that a UART uses to time its bits. It has two ways to slow the clock before a common 13-bit reload counter. The fixed path divides by 2 or by 3. The fractional path adds a 9-bit step to a 9-bit phase accumulator on every clock and emits a pulse on each carry, so its pulses arrive at f × step / 512 on average. The reload counter then takes one of every (reload + 1) of those pulses and turns it into the tick.

The reload value sits in a holding register. That register accepts a write only while the generator is stopped. A write made while the generator runs is dropped, so a running bit clock can never be disturbed halfway through a period. When the run input rises, the prescaler, the accumulator and the counter all start from known values. The first tick therefore arrives at a fixed, predictable cycle, and no stray tick appears at start-up. While the run input is low, no tick is produced.

Top module: `baud_tick_gen`

## Requirements
- R1: After a synchronous reset, tick_o is 0 and the held reload value is 0. Running in divide-by-2 mode with no reload write therefore gives a tick every 2 cycles.
- R2: While run_en is 0, tick_o stays 0 whatever the mode and step inputs are.
- R3: A write to the reload register (reload_wr = 1) takes effect only in a cycle where run_en is 0. A write made while run_en is 1 is ignored, and the tick period stays the same both during that run and in later runs.
- R4: With frac_en = 0 and pre_sel = 0, the generator emits one tick every 2 × (reload + 1) cycles. The first tick appears after the 2 × (reload + 1)-th rising edge, counting from the first edge that sees run_en = 1.
- R5: With frac_en = 0 and pre_sel = 1, the same rule holds with a factor of 3 in place of 2.
- R6: With frac_en = 1, the number of ticks after the first N edges of a run is floor(floor(N × step / 512) / (reload + 1)). This must hold for step values of 453 and 71, among others.
- R7: Reload values across the full range 0 to 8191 are supported, including both extremes.
- R8: Each rising edge of run_en restarts the prescaler, the accumulator and the counter. A run that is stopped partway through and then restarted gives its first tick at the same edge as a fresh run would.
- R9: tick_o is a registered pulse, high for exactly one cycle per tick. In fixed mode, two ticks never occur on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Generator run enable |
| frac_en | input | 1 | 1 selects the fractional path, 0 selects the fixed prescaler |
| pre_sel | input | 1 | Fixed prescaler choice: 0 gives divide-by-2, 1 gives divide-by-3 |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_din | input | 13 | New reload value |
| frac_val | input | 9 | Fractional step added on each clock |
| tick_o | output | 1 | Single-cycle oversampling tick |

## Verification
Both fixed divisors are run with a reload of 0 and with larger reloads. These runs separate a wrong prescale factor from an off-by-one error in the reload counter, because each error shifts the first tick and the tick count by a different amount. The fractional path is run with steps of 453, 71, 256 and 1. The large and small steps show whether carries are produced at the right rate. The power-of-two step gives an exactly periodic pattern, and the step of 1 tests the slowest accumulator wrap. Directed sequences then cover a run with full-scale reload, a reload write made mid-run, a stop and restart partway through a count, and idle periods with the fractional step nonzero.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int FAST_DIV = 2;
  localparam int SLOW_DIV = 3;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_FIXED = 2'd1,
    MODE_FRAC  = 2'd2
  } bg_mode_e;
endpackage

// File: rtl/bg_fixed_pre.sv
module bg_fixed_pre #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_b,
  output logic pulse
);
  localparam int CW = (DIV_B > 2) ? $clog2(DIV_B) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim   = sel_b ? CW'(DIV_B - 1) : CW'(DIV_A - 1);
  assign pulse = en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assert_pre_range_R5: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $stable(sel_b)) |-> (cnt <= lim));

  assert_pre_gap_R9: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/bg_frac_acc.sv
module bg_frac_acc #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] step,
  output logic         pulse
);
  logic [W-1:0] acc;
  logic [W:0]   sum;

  assign sum   = {1'b0, acc} + {1'b0, step};
  assign pulse = en && sum[W];

  always_ff @(posedge clk) begin
    if (rst || !en) acc <= '0;
    else            acc <= sum[W-1:0];
  end

  assert_acc_clean_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> (acc == '0));
endmodule

// File: rtl/bg_reload_cnt.sv
module bg_reload_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         pulse_in,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic         tick
);
  logic [W-1:0] reload_q;
  logic [W-1:0] cnt;
  logic         wr_ok;
  logic [W-1:0] load_val;

  assign wr_ok    = wr && !en;
  assign load_val = wr_ok ? din : reload_q;

  always_ff @(posedge clk) begin
    if (rst)        reload_q <= '0;
    else if (wr_ok) reload_q <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (!en)       cnt <= load_val;
    else if (pulse_in)  cnt <= (cnt == '0) ? reload_q : cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= en && pulse_in && (cnt == '0);
  end

  assert_reload_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> $stable(reload_q));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= reload_q);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RLD_W    = 13,
  parameter int FRAC_W   = 9,
  parameter bit HAS_FRAC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              frac_en,
  input  logic              pre_sel,
  input  logic              reload_wr,
  input  logic [RLD_W-1:0]  reload_din,
  input  logic [FRAC_W-1:0] frac_val,
  output logic              tick_o
);
  import bg_pkg::*;

  bg_mode_e mode;
  logic     fix_pulse;
  logic     frac_pulse;
  logic     pre_pulse;

  always_comb begin
    if (!run_en)                  mode = MODE_IDLE;
    else if (frac_en && HAS_FRAC) mode = MODE_FRAC;
    else                          mode = MODE_FIXED;
  end

  bg_fixed_pre #(.DIV_A(FAST_DIV), .DIV_B(SLOW_DIV)) u_fixed (
    .clk   (clk),
    .rst   (rst),
    .en    (mode == MODE_FIXED),
    .sel_b (pre_sel),
    .pulse (fix_pulse)
  );

  generate
    if (HAS_FRAC) begin : g_frac
      bg_frac_acc #(.W(FRAC_W)) u_frac (
        .clk   (clk),
        .rst   (rst),
        .en    (mode == MODE_FRAC),
        .step  (frac_val),
        .pulse (frac_pulse)
      );
    end else begin : g_nofrac
      assign frac_pulse = 1'b0;
    end
  endgenerate

  assign pre_pulse = (mode == MODE_FRAC) ? frac_pulse : fix_pulse;

  bg_reload_cnt #(.W(RLD_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (run_en),
    .pulse_in (pre_pulse),
    .wr       (reload_wr),
    .din      (reload_din),
    .tick     (tick_o)
  );

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !tick_o);

  assert_fixed_single_R9: assert property (@(posedge clk) disable iff (rst)
    (tick_o && (mode == MODE_FIXED)) |=> !tick_o);
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        frac_en = 1'b0;
  logic        pre_sel = 1'b0;
  logic        reload_wr = 1'b0;
  logic [12:0] reload_din = '0;
  logic [8:0]  frac_val = '0;
  logic        tick_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  baud_tick_gen dut (
    .clk(clk), .rst(rst), .run_en(run_en), .frac_en(frac_en),
    .pre_sel(pre_sel), .reload_wr(reload_wr), .reload_din(reload_din),
    .frac_val(frac_val), .tick_o(tick_o)
  );

  typedef struct packed {
    logic        fe;
    logic        bs;
    logic [12:0] rl;
    logic [8:0]  fd;
    int          n;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 13'd0,    9'd0,   40},
    '{1'b0, 1'b1, 13'd0,    9'd0,   40},
    '{1'b0, 1'b0, 13'd4,    9'd0,   100},
    '{1'b0, 1'b1, 13'd9,    9'd0,   301},
    '{1'b1, 1'b0, 13'd0,    9'd453, 512},
    '{1'b1, 1'b0, 13'd1,    9'd71,  1024},
    '{1'b1, 1'b0, 13'd3,    9'd256, 400},
    '{1'b0, 1'b0, 13'd8191, 9'd0,   32768},
    '{1'b1, 1'b0, 13'd0,    9'd1,   1024}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input vec_t v, input int n);
    longint carries;
    if (!v.fe) return n / ((v.bs ? 3 : 2) * (int'(v.rl) + 1));
    carries = (longint'(n) * longint'(v.fd)) / 512;
    return int'(carries / (longint'(v.rl) + 1));
  endfunction

  function automatic int exp_first(input vec_t v, input int n);
    for (int k = 1; k <= n; k++)
      if (exp_count(v, k) >= 1) return k;
    return 0;
  endfunction

  task automatic write_reload(input logic [12:0] val);
    @(negedge clk);
    reload_wr = 1'b1; reload_din = val;
    @(negedge clk);
    reload_wr = 1'b0;
  endtask

  task automatic run_window(input int n, output int cnt, output int first, output int consec);
    bit prev = 1'b0;
    cnt = 0; first = 0; consec = 0;
    @(negedge clk);
    run_en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (tick_o) begin
        cnt++;
        if (first == 0) first = k;
        if (prev) consec++;
      end
      prev = tick_o;
    end
    @(negedge clk);
    run_en = 1'b0;
  endtask

  task automatic idle_count(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (tick_o) cnt++;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, f, cs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(tick_o == 1'b0, "R1 reset tick", tick_o, 0);

    run_window(10, c, f, cs);
    check(c == 5, "R1 default reload", c, 5);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      frac_en = VECS[i].fe; pre_sel = VECS[i].bs; frac_val = VECS[i].fd;
      write_reload(VECS[i].rl);
      run_window(VECS[i].n, c, f, cs);
      check(c == exp_count(VECS[i], VECS[i].n),
            VECS[i].fe ? "R6 frac count" : (VECS[i].bs ? "R5 div3 count" : "R4 div2 count"),
            c, exp_count(VECS[i], VECS[i].n));
      check(f == exp_first(VECS[i], VECS[i].n), "R8 first tick edge", f, exp_first(VECS[i], VECS[i].n));
      if (!VECS[i].fe) check(cs == 0, "R9 no back-to-back", cs, 0);
      if (VECS[i].rl == 13'd8191) check(f == 16384, "R7 full-scale reload", f, 16384);
    end

    // R2: idle with fractional step set
    @(negedge clk);
    frac_en = 1'b1; frac_val = 9'd453;
    idle_count(60, c);
    check(c == 0, "R2 idle no ticks", c, 0);

    // R3: write during run ignored
    @(negedge clk);
    frac_en = 1'b0; pre_sel = 1'b0;
    write_reload(13'd4);
    @(negedge clk);
    run_en = 1'b1;
    c = 0;
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk); #1;
      if (tick_o) c++;
      if (k == 23) begin
        @(negedge clk); reload_wr = 1'b1; reload_din = 13'd0;
        @(posedge clk); #1;
        k++;
        if (tick_o) c++;
        @(negedge clk); reload_wr = 1'b0;
      end
    end
    @(negedge clk);
    run_en = 1'b0;
    check(c == 10, "R3 write during run ignored", c, 10);
    run_window(100, c, f, cs);
    check(c == 10, "R3 later run keeps reload", c, 10);
    check(f == 10, "R3 later run first tick", f, 10);

    // R8: stop partway, restart
    run_window(7, c, f, cs);
    check(c == 0, "R8 partial run no tick", c, 0);
    run_window(25, c, f, cs);
    check(f == 10, "R8 restart first tick", f, 10);
    check(c == 2, "R8 restart count", c, 2);

    // R3: write accepted when idle, then run immediately
    write_reload(13'd1);
    run_window(12, c, f, cs);
    check(f == 4, "R3 idle write accepted", f, 4);

    // R1: reset clears reload
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(tick_o == 1'b0, "R1 tick after reset", tick_o, 0);
    run_window(10, c, f, cs);
    check(c == 5, "R1 reload cleared", c, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule